// File: doc/BRIEF.md
# I2C SCL Rate Generator

This block turns a six-bit divider code and a filter sample-rate value into the number of system-clock cycles in one SCL bit period. It then times the low and high halves of SCL for an I2C master. The code is split into two fields. One field gives a power-of-two prescale. The other gives a non-linear base multiplier. The filter sample rate adds a correction term, so the period grows when the input filter samples more slowly.

The divider is recomputed on every cycle while the controller is disabled and is frozen while it runs. Software may therefore rewrite the code at any time, and the new value takes effect at the next enable. While enabled, the block drives a level that starts low and flips every half period. It also drives a one-cycle strobe at the start of each phase. The computed period is visible on an output.

Top module: `scl_rate_gen`

## Requirements
- R1: Code bits [4:2] hold an exponent g, and the prescale B equals 16 << g, which ranges from 16 to 2048.
- R2: The multiplier code is {code[5], code[1:0]}, with code[5] as its most significant bit. Multiplier codes 0 to 7 select the base term A as 18, 20, 24, 30, 10, 12, 14, 16.
- R3: With d the effective filter rate, the period is N = B * (A + 2 * floor(3*d / B)). Every N is a multiple of 16 and at least 160.
- R4: A filter rate of 0 is used as 1, so it gives the same period as a filter rate of 1.
- R5: `div_value` takes the decoded period one cycle after any clock edge at which `en` is low. At edges where `en` is high it holds its value, so a code or rate change made while enabled appears only after `en` goes low.
- R6: After `en` rises, `scl_level` is low for N/2 cycles, then high for N/2 cycles, and the pattern repeats for as long as `en` stays high.
- R7: `scl_tick` is high for exactly the one cycle in which each phase begins: the first low cycle after enable and every change of `scl_level`. It is low otherwise.
- R8: While `en` is low, `scl_level` is high and `scl_tick` is low. During reset both hold these idle values, and `div_value` holds 3072, which is the period of the fallback code 0x31 at the default filter rate of 5 for a 100 MHz clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Controller enable; the divider is frozen while high |
| ratio_code | input | 6 | Divider code: prescale exponent and multiplier fields |
| filt_rate | input | DFSR_W (6) | Filter sample rate; 0 is used as 1 |
| div_value | output | DIV_W (17) | Decoded SCL period in system-clock cycles |
| scl_level | output | 1 | SCL phase: 0 low, 1 high (idle) |
| scl_tick | output | 1 | One-cycle strobe at the start of each phase |

## Verification
A wrong field split or a wrong multiplier entry shows on `div_value` one cycle after the code is applied with `en` low, so each code is checked in that same cycle. A faulty freeze shows as `div_value` moving while `en` is high, within one cycle of the input change. A wrong phase counter or a wrong half-length shows as a low or high phase of the wrong length, or as a strobe missing at a level change. This appears within the first period after enable, at most a few thousand cycles later.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  localparam int CODE_W   = 6;
  localparam int DIV_W    = 17;
  localparam int RATE_PAD = 8;

  // Base multiplier selected by {code[5], code[1:0]}
  function automatic logic [4:0] base_mult(input logic [2:0] sel);
    logic [4:0] a;
    unique case (sel)
      3'd0: a = 5'd18;
      3'd1: a = 5'd20;
      3'd2: a = 5'd24;
      3'd3: a = 5'd30;
      3'd4: a = 5'd10;
      3'd5: a = 5'd12;
      3'd6: a = 5'd14;
      default: a = 5'd16;
    endcase
    return a;
  endfunction

  // Period = B * (A + 2*floor(3*d/B)), with B = 1 << (4 + g)
  function automatic logic [DIV_W-1:0] period_of(input logic [CODE_W-1:0]   code,
                                                 input logic [RATE_PAD-1:0] rate);
    logic [RATE_PAD-1:0] eff;
    logic [3:0]          shamt;
    logic [9:0]          triple;
    logic [9:0]          corr;
    logic [DIV_W-1:0]    sum;
    eff    = (rate == '0) ? RATE_PAD'(1) : rate;
    shamt  = 4'd4 + {1'b0, code[4:2]};
    triple = 10'(eff) * 10'd3;
    corr   = triple >> shamt;
    sum    = DIV_W'(base_mult({code[5], code[1:0]})) + DIV_W'({corr, 1'b0});
    return sum << shamt;
  endfunction

endpackage

// File: rtl/scl_code_decode.sv
module scl_code_decode
  import scl_div_pkg::*;
#(
  parameter int DFSR_W = 6
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [DFSR_W-1:0] rate_i,
  output logic [DIV_W-1:0]  period_o
);

  logic [RATE_PAD-1:0] rate_ext;

  always_comb begin
    rate_ext = RATE_PAD'(rate_i);
    period_o = period_of(code_i, rate_ext);
  end

endmodule

// File: rtl/scl_period_reg.sv
module scl_period_reg
  import scl_div_pkg::*;
#(
  parameter logic [DIV_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] period_i,
  output logic [DIV_W-1:0] period_q
);

  logic             load_en;
  logic [DIV_W-1:0] period_d;

  always_comb begin
    load_en  = ~en_i;
    period_d = load_en ? period_i : period_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) period_q <= RST_VAL;
    else        period_q <= period_d;
  end

  // R5: frozen while the controller runs
  p_hold_while_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> $stable(period_q));

  // R3: every legal period is a multiple of 16 and at least 160
  p_period_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q[3:0] == 4'd0) && (period_q >= DIV_W'(160)));

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
  import scl_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] period_i,
  output logic             level_o,
  output logic             tick_o
);

  logic             run_q, run_d;
  logic             lvl_q, lvl_d;
  logic             tick_q, tick_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] high_len, low_len;

  always_comb begin
    high_len = period_i >> 1;
    low_len  = period_i - high_len;
    run_d    = run_q;
    lvl_d    = lvl_q;
    cnt_d    = cnt_q;
    tick_d   = 1'b0;
    if (!en_i) begin
      run_d = 1'b0;
      lvl_d = 1'b1;
      cnt_d = '0;
    end else if (!run_q) begin
      run_d  = 1'b1;
      lvl_d  = 1'b0;
      cnt_d  = low_len - DIV_W'(1);
      tick_d = 1'b1;
    end else if (cnt_q == '0) begin
      lvl_d  = ~lvl_q;
      cnt_d  = lvl_q ? (low_len - DIV_W'(1)) : (high_len - DIV_W'(1));
      tick_d = 1'b1;
    end else begin
      cnt_d = cnt_q - DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      lvl_q  <= 1'b1;
      tick_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      run_q  <= run_d;
      lvl_q  <= lvl_d;
      tick_q <= tick_d;
      cnt_q  <= cnt_d;
    end
  end

  assign level_o = lvl_q;
  assign tick_o  = tick_q;

  // R8: disabled means idle-high with no strobe
  p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (lvl_q && !tick_q));

  // R7: a level change while running always carries the strobe
  p_change_has_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_i) && !$stable(lvl_q)) |-> tick_q);

  // R6: the phase counter never exceeds the longer half
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && en_i) |-> (cnt_q < low_len));

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_div_pkg::*;
#(
  parameter int DFSR_W  = 6,
  parameter int CLK_KHZ = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] ratio_code,
  input  logic [DFSR_W-1:0] filt_rate,
  output logic [DIV_W-1:0]  div_value,
  output logic              scl_level,
  output logic              scl_tick
);

  localparam logic [CODE_W-1:0]   FALLBACK_CODE = 6'h31;
  localparam int                  DEF_RATE_I    = (5 * CLK_KHZ) / 100000;
  localparam logic [RATE_PAD-1:0] DEF_RATE      = RATE_PAD'(DEF_RATE_I);
  localparam logic [DIV_W-1:0]    RST_PERIOD    = period_of(FALLBACK_CODE, DEF_RATE);

  logic [DIV_W-1:0] period_dec;

  scl_code_decode #(.DFSR_W(DFSR_W)) u_decode (
    .code_i   (ratio_code),
    .rate_i   (filt_rate),
    .period_o (period_dec)
  );

  scl_period_reg #(.RST_VAL(RST_PERIOD)) u_period (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en),
    .period_i (period_dec),
    .period_q (div_value)
  );

  scl_phase_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en),
    .period_i (div_value),
    .level_o  (scl_level),
    .tick_o   (scl_tick)
  );

endmodule

// File: tb/scl_rate_gen_tb.sv
module scl_rate_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 200000;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [5:0]  ratio_code;
  logic [5:0]  filt_rate;
  logic [16:0] div_value;
  logic        scl_level;
  logic        scl_tick;

  int n_checks;
  int n_fail;
  bit done;

  scl_rate_gen dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .ratio_code (ratio_code),
    .filt_rate  (filt_rate),
    .div_value  (div_value),
    .scl_level  (scl_level),
    .scl_tick   (scl_tick)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_period(input int code, input int rate);
    int g, b, a, sel, d;
    g   = (code >> 2) & 7;
    b   = 16 << g;
    sel = (((code >> 5) & 1) << 2) | (code & 3);
    case (sel)
      0: a = 18; 1: a = 20; 2: a = 24; 3: a = 30;
      4: a = 10; 5: a = 12; 6: a = 14; default: a = 16;
    endcase
    d = (rate == 0) ? 1 : rate;
    return b * (a + 2 * ((3 * d) / b));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input int code, input int rate, input string req);
    @(negedge clk);
    en = 1'b0; ratio_code = 6'(code); filt_rate = 6'(rate);
    @(posedge clk); #1;
    check(int'(div_value) == exp_period(code, rate), req, int'(div_value), exp_period(code, rate));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0; ratio_code = 6'h20; filt_rate = 6'd1;
    repeat (3) @(posedge clk);
    #1;
    check(int'(div_value) == 3072, "R8 reset period", int'(div_value), 3072);
    check(scl_level == 1'b1, "R8 reset level", int'(scl_level), 1);
    check(scl_tick == 1'b0, "R8 reset tick", int'(scl_tick), 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_prescale();
    for (int g = 0; g < 8; g++) load(32 | (g << 2), 1, "R1 prescale sweep");
  endtask

  task automatic t_multiplier();
    for (int s = 0; s < 8; s++) load(((s >> 2) << 5) | (s & 3), 1, "R2 multiplier sweep");
  endtask

  task automatic t_correction();
    load(6'h20, 63, "R3 correction B=16 d=63");
    check(int'(div_value) == 512, "R3 literal 512", int'(div_value), 512);
    load(6'h27, 20, "R3 correction B=32 d=20");
    load(6'h08, 63, "R3 correction B=64 d=63");
    load(6'h3F, 40, "R3 correction B=2048");
  endtask

  task automatic t_rate_zero();
    int p1;
    load(6'h20, 1, "R4 rate one");
    p1 = int'(div_value);
    load(6'h20, 0, "R4 rate zero");
    check(int'(div_value) == p1, "R4 zero equals one", int'(div_value), p1);
    load(6'h13, 0, "R4 rate zero other code");
  endtask

  task automatic t_hold();
    load(6'h20, 1, "R5 preload");
    @(negedge clk); en = 1'b1; ratio_code = 6'h07; filt_rate = 6'd9;
    repeat (6) @(posedge clk);
    #1;
    check(int'(div_value) == 160, "R5 frozen while enabled", int'(div_value), 160);
    @(negedge clk); en = 1'b0;
    @(posedge clk); #1;
    check(int'(div_value) == exp_period(6'h07, 9), "R5 reload after disable",
          int'(div_value), exp_period(6'h07, 9));
  endtask

  task automatic t_phase(input int code, input int rate);
    int n, lo, hi, mid_ticks;
    n = exp_period(code, rate);
    load(code, rate, "R6 phase preload");
    @(negedge clk); en = 1'b1;
    @(posedge clk); #1;
    check(scl_level == 1'b0, "R6 first phase low", int'(scl_level), 0);
    check(scl_tick == 1'b1, "R7 tick at enable", int'(scl_tick), 1);
    for (int rep = 0; rep < 2; rep++) begin
      lo = 1; mid_ticks = 0;
      forever begin
        @(posedge clk); #1;
        if (scl_level != 1'b0) break;
        lo++;
        if (scl_tick) mid_ticks++;
      end
      check(lo == n / 2, "R6 low length", lo, n / 2);
      check(scl_tick == 1'b1, "R7 tick at rise", int'(scl_tick), 1);
      hi = 1;
      forever begin
        @(posedge clk); #1;
        if (scl_level != 1'b1) break;
        hi++;
        if (scl_tick) mid_ticks++;
      end
      check(hi == n / 2, "R6 high length", hi, n / 2);
      check(scl_tick == 1'b1, "R7 tick at fall", int'(scl_tick), 1);
      check(mid_ticks == 0, "R7 no tick inside phase", mid_ticks, 0);
    end
    @(negedge clk); en = 1'b0;
    @(posedge clk); #1;
    check(scl_level == 1'b1 && scl_tick == 1'b0, "R8 idle after disable",
          {scl_level, scl_tick}, 2);
    repeat (20) @(posedge clk);
    #1;
    check(scl_level == 1'b1 && scl_tick == 1'b0, "R8 idle stays", {scl_level, scl_tick}, 2);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    t_reset();
    t_prescale();
    t_multiplier();
    t_correction();
    t_rate_zero();
    t_hold();
    t_phase(6'h20, 1);
    t_phase(6'h20, 63);
    t_phase(6'h27, 20);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", MAX_CYC, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule